// File: doc/BRIEF.md
# Two-Clock Show-Ahead FIFO with Level Flags

This block carries 18-bit words from one clock domain to an unrelated one. Its storage array holds 2^AW words, and the read-side output register holds one word more, so the FIFO stores up to 2^AW + 1 words. Reads work in show-ahead style. When a word reaches the output register, the valid flag drops and the word is already on `rd_data`. A read-enable pulse takes that word, and the next stored word moves into the output register on the same read-clock edge.

Each side keeps a binary pointer and sends its Gray-coded form across through a two-flop synchronizer. The write side uses two pointers from the read side. One counts the words read out, and it drives the level flags. The other counts the words moved out of the array, and it guards the array against overwrite. Each domain works out its fill level from its own pointer and the synchronized pointer from the other side. It then registers its flags from the level the next cycle will have. All flags are active-low. The almost-empty and almost-full offsets are fixed by parameters.

Top module: `dcfifo_fwft`

## Requirements
- R1: During and directly after reset, `rd_valid_n`=1, `wr_ready_n`=0, `rd_almost_empty_n`=0, `rd_half_full_n`=1 and `wr_almost_full_n`=1.
- R2: The FIFO accepts exactly CAP = 2^AW + 1 words with no reads. `wr_ready_n` goes to 1 right after the edge that writes word CAP.
- R3: A write attempted while `wr_ready_n`=1 changes nothing. Its data never shows up at the output, and the write pointer does not move.
- R4: After a word is written into an empty FIFO, `rd_valid_n` goes to 0 on the third rising `rd_clk` edge after the write edge. If the two edges are too close together, this happens on the fourth edge. The word is on `rd_data` by then, with no `rd_en`.
- R5: A rising `rd_clk` edge with `rd_en`=1 and `rd_valid_n`=0 consumes the word on `rd_data`. On that same edge the next stored word is presented, or `rd_valid_n` returns to 1 if none is stored. Words come out in the order they were written.
- R6: `rd_en` while `rd_valid_n`=1 has no effect on the words read later.
- R7: `rd_almost_empty_n` is 0 while the read-side level is at most AE_OFS+1. It is 1 once the level reaches AE_OFS+2. The flag is registered in the `rd_clk` domain.
- R8: `wr_almost_full_n` is 0 while the write-side level is at least CAP−AF_OFS. It is registered in the `wr_clk` domain. `wr_ready_n`=1 implies `wr_almost_full_n`=0.
- R9: `rd_half_full_n` is 0 while the read-side level exceeds 2^(AW−1) = (CAP−1)/2. Half-full never coincides with almost-empty.
- R10: A pointer crosses between the domains only as a Gray code, and that code changes at most one bit per clock. Data stays intact between unrelated clocks.
- R11: While `rd_valid_n`=0 and `rd_en`=0, `rd_data` and `rd_valid_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Active-high reset, synchronous in each domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_ready_n | output | 1 | Low while a write can be accepted |
| wr_almost_full_n | output | 1 | Low when the write-side level is at or above CAP−AF_OFS |
| rd_en | input | 1 | Consume the word on `rd_data` |
| rd_data | output | DW | Show-ahead output register |
| rd_valid_n | output | 1 | Low while `rd_data` holds a word |
| rd_almost_empty_n | output | 1 | Low while the read-side level is at most AE_OFS+1 |
| rd_half_full_n | output | 1 | Low while the read-side level exceeds 2^(AW−1) |

## Verification
The assertions check on every clock several rules that hold in any traffic. A refused write leaves the write pointer unchanged. Every crossing Gray code moves at most one bit. A held output word stays stable. A read with nothing valid leaves the consumed pointer alone. The flag pairs stay consistent: full goes with almost-full, and half-full excludes almost-empty. Other behaviours only the directed scenarios can show, because they depend on counted levels and on timing between the two clocks. These are the exact capacity, the fall-through latency in read-clock edges, the threshold at which each flag switches, and the order of the words under traffic on unrelated clocks.

// File: rtl/fifo_fwft_pkg.sv
package fifo_fwft_pkg;

  // binary to reflected Gray code, 32-bit container
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray code back to binary, 32-bit container
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/fifo_sync_bus.sv
module fifo_sync_bus #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/fifo_dp_ram.sv
module fifo_dp_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port doubles as the show-ahead output register
  always_ff @(posedge rclk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import fifo_fwft_pkg::*;
#(
  parameter int AW     = 8,
  parameter int AF_OFS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen,
  input  logic [AW:0]   cgray_s,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          ready_n,
  output logic          afull_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CAP   = DEPTH + 1;
  localparam logic [PW-1:0] CAP_L   = PW'(CAP);
  localparam logic [PW-1:0] DEPTH_L = PW'(DEPTH);
  localparam logic [PW-1:0] AF_L    = PW'(CAP - AF_OFS);

  logic [PW-1:0] wbin, wbin_nx, cbin_s, rbin_s, lvl_nx, arr_nx;
  logic          accept, full_nx;
  logic [31:0]   c_wide, r_wide, g_wide;

  assign c_wide = gray_to_bin(32'(cgray_s));
  assign r_wide = gray_to_bin(32'(rgray_s));
  assign cbin_s = c_wide[PW-1:0];
  assign rbin_s = r_wide[PW-1:0];

  assign accept  = wen && !ready_n && !rst;
  assign wbin_nx = wbin + PW'(accept);
  assign lvl_nx  = wbin_nx - cbin_s;   // words not yet consumed by the reader
  assign arr_nx  = wbin_nx - rbin_s;   // words still inside the array
  assign full_nx = (lvl_nx >= CAP_L) || (arr_nx >= DEPTH_L);
  assign g_wide  = bin_to_gray(32'(wbin_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      ready_n <= 1'b0;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= g_wide[PW-1:0];
      ready_n <= full_nx;
      afull_n <= !(lvl_nx >= AF_L);
    end
  end

  assign we    = accept;
  assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_fwft_pkg::*;
#(
  parameter int AW     = 8,
  parameter int AE_OFS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren,
  input  logic [AW:0]   wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   cgray,
  output logic          valid_n,
  output logic          aempty_n,
  output logic          half_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] AE_L   = PW'(AE_OFS + 1);
  localparam logic [PW-1:0] HALF_L = PW'(DEPTH / 2);

  logic [PW-1:0] rbin, cbin, rbin_nx, cbin_nx, wbin_s, lvl_nx;
  logic          held, arr_has, pop, fetch, held_nx;
  logic [31:0]   w_wide, rg_wide, cg_wide;

  assign w_wide = gray_to_bin(32'(wgray_s));
  assign wbin_s = w_wide[PW-1:0];

  assign held    = !valid_n;
  assign arr_has = (wbin_s != rbin);
  assign pop     = ren && held && !rst;
  assign fetch   = arr_has && (!held || pop) && !rst;
  assign held_nx = fetch ? 1'b1 : (pop ? 1'b0 : held);

  assign rbin_nx = rbin + PW'(fetch);
  assign cbin_nx = cbin + PW'(pop);
  assign lvl_nx  = wbin_s - cbin_nx;   // array plus output register
  assign rg_wide = bin_to_gray(32'(rbin_nx));
  assign cg_wide = bin_to_gray(32'(cbin_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      cbin     <= '0;
      rgray    <= '0;
      cgray    <= '0;
      valid_n  <= 1'b1;
      aempty_n <= 1'b0;
      half_n   <= 1'b1;
    end else begin
      rbin     <= rbin_nx;
      cbin     <= cbin_nx;
      rgray    <= rg_wide[PW-1:0];
      cgray    <= cg_wide[PW-1:0];
      valid_n  <= !held_nx;
      aempty_n <= (lvl_nx > AE_L);
      half_n   <= !(lvl_nx > HALF_L);
    end
  end

  assign re    = fetch;
  assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft #(
  parameter int DW     = 18,
  parameter int AW     = 8,
  parameter int AE_OFS = 4,
  parameter int AF_OFS = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready_n,
  output logic          wr_almost_full_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid_n,
  output logic          rd_almost_empty_n,
  output logic          rd_half_full_n
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_gray, rptr_gray, cptr_gray;
  logic [PW-1:0] wptr_gray_s, rptr_gray_s, cptr_gray_s;
  logic          ram_we, ram_re;
  logic [AW-1:0] ram_waddr, ram_raddr;

  fifo_sync_bus #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst(rst), .d(wptr_gray), .q(wptr_gray_s)
  );
  fifo_sync_bus #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst(rst), .d(rptr_gray), .q(rptr_gray_s)
  );
  fifo_sync_bus #(.W(PW)) u_sync_c2w (
    .clk(wr_clk), .rst(rst), .d(cptr_gray), .q(cptr_gray_s)
  );

  fifo_wr_ctl #(.AW(AW), .AF_OFS(AF_OFS)) u_wr (
    .clk(wr_clk), .rst(rst), .wen(wr_en),
    .cgray_s(cptr_gray_s), .rgray_s(rptr_gray_s),
    .we(ram_we), .waddr(ram_waddr), .wgray(wptr_gray),
    .ready_n(wr_ready_n), .afull_n(wr_almost_full_n)
  );

  fifo_rd_ctl #(.AW(AW), .AE_OFS(AE_OFS)) u_rd (
    .clk(rd_clk), .rst(rst), .ren(rd_en), .wgray_s(wptr_gray_s),
    .re(ram_re), .raddr(ram_raddr), .rgray(rptr_gray), .cgray(cptr_gray),
    .valid_n(rd_valid_n), .aempty_n(rd_almost_empty_n),
    .half_n(rd_half_full_n)
  );

  fifo_dp_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(ram_re), .raddr(ram_raddr), .q(rd_data)
  );
endmodule

// File: rtl/fifo_fwft_chk.sv
module fifo_fwft_chk #(
  parameter int DW     = 18,
  parameter int AW     = 8,
  parameter int AE_OFS = 4,
  parameter int AF_OFS = 4
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_ready_n,
  input logic          wr_almost_full_n,
  input logic [AW:0]   wgray,
  input logic          rd_en,
  input logic          rd_valid_n,
  input logic [DW-1:0] rd_data,
  input logic          rd_almost_empty_n,
  input logic          rd_half_full_n,
  input logic [AW:0]   rgray,
  input logic [AW:0]   cgray
);
  localparam int HALF = (1 << AW) / 2;

  logic w_arm, r_arm;
  always_ff @(posedge wr_clk) w_arm <= rst ? 1'b0 : 1'b1;
  always_ff @(posedge rd_clk) r_arm <= rst ? 1'b0 : 1'b1;

  assert_refused_write_R3: assert property (@(posedge wr_clk) disable iff (rst || !w_arm)
    (wr_en && wr_ready_n) |=> $stable(wgray));

  assert_wgray_step_R10: assert property (@(posedge wr_clk) disable iff (rst || !w_arm)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R10: assert property (@(posedge rd_clk) disable iff (rst || !r_arm)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_cgray_step_R10: assert property (@(posedge rd_clk) disable iff (rst || !r_arm)
    $countones(cgray ^ $past(cgray)) <= 1);

  assert_hold_word_R11: assert property (@(posedge rd_clk) disable iff (rst || !r_arm)
    (!rd_valid_n && !rd_en) |=> (!rd_valid_n && $stable(rd_data)));

  assert_consume_moves_R5: assert property (@(posedge rd_clk) disable iff (rst || !r_arm)
    (!rd_valid_n && rd_en) |=> (cgray != $past(cgray)));

  assert_idle_read_R6: assert property (@(posedge rd_clk) disable iff (rst || !r_arm)
    (rd_valid_n && rd_en) |=> $stable(cgray));

  generate
    if (AF_OFS >= 1) begin : g_af
      assert_full_has_af_R8: assert property (@(posedge wr_clk) disable iff (rst || !w_arm)
        wr_ready_n |-> !wr_almost_full_n);
    end
    if (AE_OFS < HALF) begin : g_hf
      assert_half_not_ae_R9: assert property (@(posedge rd_clk) disable iff (rst || !r_arm)
        !rd_half_full_n |-> rd_almost_empty_n);
    end
  endgenerate
endmodule

bind dcfifo_fwft fifo_fwft_chk #(
  .DW(DW), .AW(AW), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
  .wr_en(wr_en), .wr_ready_n(wr_ready_n), .wr_almost_full_n(wr_almost_full_n),
  .wgray(wptr_gray),
  .rd_en(rd_en), .rd_valid_n(rd_valid_n), .rd_data(rd_data),
  .rd_almost_empty_n(rd_almost_empty_n), .rd_half_full_n(rd_half_full_n),
  .rgray(rptr_gray), .cgray(cptr_gray)
);

// File: tb/dcfifo_fwft_test.sv
module dcfifo_fwft_test;
  localparam int DW  = 18;
  localparam int AW  = 4;
  localparam int AEO = 3;
  localparam int AFO = 3;
  localparam int CAP = (1 << AW) + 1;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_ready_n, wr_almost_full_n, rd_valid_n, rd_almost_empty_n, rd_half_full_n;

  int tests = 0;
  int fails = 0;

  dcfifo_fwft #(.DW(DW), .AW(AW), .AE_OFS(AEO), .AF_OFS(AFO)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ready_n(wr_ready_n),
    .wr_almost_full_n(wr_almost_full_n),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid_n(rd_valid_n),
    .rd_almost_empty_n(rd_almost_empty_n), .rd_half_full_n(rd_half_full_n)
  );

  always #10 wr_clk = ~wr_clk;               // 50 MHz
  initial begin #7; forever #14 rd_clk = ~rd_clk; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_force(input logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge wr_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge wr_clk);
    while (wr_ready_n) @(negedge wr_clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge wr_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [DW-1:0] v);
    @(negedge rd_clk);
    while (rd_valid_n) @(negedge rd_clk);
    v = rd_data; rd_en = 1'b1;
    @(posedge rd_clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (6) @(posedge rd_clk);
    #1;
    check("R1 valid_n in reset", 32'(rd_valid_n), 1);
    @(negedge wr_clk); rst = 1'b0;
    @(posedge wr_clk); #1;
    check("R1 ready_n", 32'(wr_ready_n), 0);
    check("R1 almost_full_n", 32'(wr_almost_full_n), 1);
    @(posedge rd_clk); #1;
    check("R1 valid_n", 32'(rd_valid_n), 1);
    check("R1 almost_empty_n", 32'(rd_almost_empty_n), 0);
    check("R1 half_full_n", 32'(rd_half_full_n), 1);
  endtask

  task automatic t_first_word();
    logic [DW-1:0] v;
    int n = 0;
    push_force(18'h2A5A5);
    while (rd_valid_n && n < 10) begin
      @(posedge rd_clk); #1; n++;
    end
    check("R4 fall-through edges ok", 32'(n == 3 || n == 4), 1);
    check("R4 word shown without rd_en", 32'(rd_data), 32'h2A5A5);
    repeat (3) @(posedge rd_clk); #1;
    check("R11 word held", 32'(rd_data), 32'h2A5A5);
    check("R7 single word is almost empty", 32'(rd_almost_empty_n), 0);
    pop(v);
    check("R5 popped value", 32'(v), 32'h2A5A5);
    check("R5 valid_n after last pop", 32'(rd_valid_n), 1);
  endtask

  task automatic t_idle_read();
    logic [DW-1:0] v;
    int bad = 0;
    @(negedge rd_clk); rd_en = 1'b1;
    repeat (5) begin
      @(posedge rd_clk); #1;
      if (rd_valid_n !== 1'b1) bad++;
    end
    rd_en = 1'b0;
    check("R6 no valid during idle reads", 32'(bad), 0);
    push(18'h00111);
    push(18'h00222);
    pop(v); check("R6 first after idle reads", 32'(v), 32'h00111);
    pop(v); check("R6 second after idle reads", 32'(v), 32'h00222);
  endtask

  task automatic t_fill_drain();
    logic [DW-1:0] v;
    int bad_ir = 0, bad_af = 0, bad_d = 0, bad_hf = 0, bad_ae = 0;
    settle();
    for (int i = 0; i < CAP; i++) begin
      push_force(DW'(18'h100 + i));
      if (wr_ready_n !== ((i == CAP - 1) ? 1'b1 : 1'b0)) bad_ir++;
      if (wr_almost_full_n !== ((i + 1 >= CAP - AFO) ? 1'b0 : 1'b1)) bad_af++;
    end
    check("R2 ready_n across fill", 32'(bad_ir), 0);
    check("R8 almost_full_n across fill", 32'(bad_af), 0);
    push_force(18'h3FFFF);
    check("R3 still full after refused write", 32'(wr_ready_n), 1);
    settle();
    check("R9 half_full_n when full", 32'(rd_half_full_n), 0);
    check("R7 almost_empty_n when full", 32'(rd_almost_empty_n), 1);
    for (int i = 0; i < CAP; i++) begin
      int r;
      pop(v);
      r = CAP - 1 - i;
      if (v !== DW'(18'h100 + i)) bad_d++;
      if (rd_half_full_n !== ((r > (1 << AW) / 2) ? 1'b0 : 1'b1)) bad_hf++;
      if (rd_almost_empty_n !== ((r > AEO + 1) ? 1'b1 : 1'b0)) bad_ae++;
    end
    check("R2 R3 drain order", 32'(bad_d), 0);
    check("R9 half_full_n across drain", 32'(bad_hf), 0);
    check("R7 almost_empty_n across drain", 32'(bad_ae), 0);
    settle();
    check("R3 refused word absent", 32'(rd_valid_n), 1);
    check("R8 almost_full_n after drain", 32'(wr_almost_full_n), 1);
    check("R2 ready_n after drain", 32'(wr_ready_n), 0);
  endtask

  task automatic t_stream();
    int bad = 0;
    fork
      begin
        for (int i = 0; i < 60; i++) push(DW'(18'h2000 + i));
      end
      begin
        for (int i = 0; i < 60; i++) begin
          logic [DW-1:0] v;
          pop(v);
          if (v !== DW'(18'h2000 + i)) bad++;
          if (i % 3 == 2) repeat (2) @(posedge rd_clk);
        end
      end
    join
    check("R5 R10 stream order", 32'(bad), 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_first_word();
    t_idle_read();
    t_fill_drain();
    t_stream();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule